// File: doc/BRIEF.md
# Down-Counting Compare Timer

This block is a 32-bit timer that sits on a simple synchronous register bus. A down-counter steps once for every (prescale+1) cycles of the block clock while the timer is running. When the counter moves onto the value held in the compare register, a sticky event flag is raised. Software clears that flag by writing a one to it. The flag, gated by an enable bit, forms the interrupt line. The same event also drives an output pin that can toggle, go low, go high or stay disconnected.

When the counter leaves zero, it either takes the value of the load register (reload mode) or wraps to all ones (free-running mode). A control bit lets a write to the load register replace the running count at once. Because the count falls over time, software that wants an up-count negates the value it reads. A soft-reset bit in the control word returns the counter, status and control state to zero. The bit is visible for one cycle and then clears itself.

Top module: `cmp_dn_timer`

## Requirements
- R1: After the asynchronous reset, every register reads zero, and `irq` and `pin_out` are low.
- R2: With control bit 0 (run) set and prescale P in control bits 15:4, the counter falls by one every P+1 clock cycles. The first step comes P+1 cycles after the edge that sets run. With run clear, the counter holds.
- R3: With control bit 3 (reload) clear, a step from zero gives 0xFFFFFFFF.
- R4: With reload set, a step from zero gives the value of the load register (offset 0x08).
- R5: A write to the load register while control bit 17 (force) is set puts the written value into the counter on that edge. With force clear, the counter is unaffected.
- R6: A step that makes the counter equal the compare register (offset 0x0C) sets status bit 0 (offset 0x04) on that edge.
- R7: Writing 1 to status bit 0 clears it and writing 0 has no effect. If an event and a clear fall on the same edge, the flag ends up set.
- R8: `irq` is high exactly when the status flag is set and control bit 2 (interrupt enable) is set.
- R9: Control bits 23:22 select the pin action on an event: 1 toggles, 2 drives low, 3 drives high. In mode 0, `pin_out` is held low.
- R10: A control write with bit 16 set clears the control fields at once and reads back 0x00010000 for one cycle. On the next edge it clears the counter, the status flag and the pin state, and the bit then reads zero. The load and compare registers keep their values.
- R11: The counter register (offset 0x10) is read-only: writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |
| pin_out | output | 1 | Event-driven output pin |

## Verification
The bench checks the count on the exact cycle of each step. With a non-zero prescale, a design whose divider is off by one shows the step one read early or late. The zero crossing is tested in both modes, so a design that reloads when it should wrap, or the other way round, returns the wrong value right after zero. An event written in the same cycle as a flag clear catches a design that lets the clear win. After a soft reset, the pin is re-enabled in toggle mode to expose pin state that survived the reset, and the load register is read to catch a reset that clears too much.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int PRE_W     = 12;
  localparam int B_RUN     = 0;
  localparam int B_IRQEN   = 2;
  localparam int B_RELOAD  = 3;
  localparam int B_PRE_LO  = 4;
  localparam int B_SRST    = 16;
  localparam int B_FORCE   = 17;
  localparam int B_MODE_LO = 22;

  typedef enum logic [1:0] {
    PIN_OFF    = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_LOW    = 2'd2,
    PIN_HIGH   = 2'd3
  } pin_mode_e;

  typedef struct packed {
    logic             run;
    logic             irq_en;
    logic             reload;
    logic             force_ld;
    logic [PRE_W-1:0] presc;
    pin_mode_e        mode;
  } ctrl_t;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [PW-1:0] limit,
  output logic          tick
);
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          at_lim;

  assign at_lim = (pcnt_q == limit);
  assign tick   = run & at_lim & ~clr;

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr || !run)  pcnt_d = '0;
    else if (at_lim)  pcnt_d = '0;
    else              pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R2: the divider restarts after each tick and rests at zero while stopped
  p_restart_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pcnt_q == '0));
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pcnt_q == '0));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic         reload,
  input  logic [W-1:0] load_val,
  input  logic         force_wr,
  input  logic [W-1:0] force_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] step_val
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == '0) step_val = reload ? load_val : '1;
    else             step_val = cnt_q - 1'b1;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr)           cnt_d = '0;
    else if (force_wr) cnt_d = force_val;
    else if (tick)     cnt_d = step_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !force_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !force_wr && cnt_q == '0 && !reload) |=> (cnt_q == '1));
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !force_wr && cnt_q == '0 && reload) |=> (cnt_q == $past(load_val)));
  p_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (force_wr && !clr) |=> (cnt_q == $past(force_val)));
endmodule

// File: rtl/cdt_event.sv
module cdt_event
  import cdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      evt,
  input  logic      clr_req,
  input  pin_mode_e mode,
  output logic      flag,
  output logic      pin_o
);
  logic flag_q, flag_d, pin_q, pin_d;

  always_comb begin
    flag_d = flag_q;
    if (clr)          flag_d = 1'b0;
    else if (evt)     flag_d = 1'b1;
    else if (clr_req) flag_d = 1'b0;
  end

  always_comb begin
    pin_d = pin_q;
    if (clr) pin_d = 1'b0;
    else if (evt) begin
      case (mode)
        PIN_TOGGLE: pin_d = ~pin_q;
        PIN_LOW:    pin_d = 1'b0;
        PIN_HIGH:   pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      pin_q  <= pin_d;
    end
  end

  assign flag  = flag_q;
  assign pin_o = (mode == PIN_OFF) ? 1'b0 : pin_q;

  p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !clr) |=> flag_q);
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !evt) |=> !flag_q);
  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !clr && mode == PIN_TOGGLE) |=> (pin_q != $past(pin_q)));
endmodule

// File: rtl/cmp_dn_timer.sv
module cmp_dn_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              pin_out
);
  localparam int DATA_W = 32;
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_STAT = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_LOAD = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_CMP  = WORD_W'(3);
  localparam logic [WORD_W-1:0] W_CNT  = WORD_W'(4);

  ctrl_t             ctrl_q, ctrl_d;
  logic              srst_q, srst_d;
  logic [CNT_W-1:0]  load_q, load_d, cmp_q, cmp_d;
  logic [CNT_W-1:0]  cnt, step_val;
  logic [WORD_W-1:0] word;
  logic              wr_ok, wr_ctrl, wr_stat, wr_load, wr_cmp, wr_cnt;
  logic              tick, force_wr, evt, flag;

  assign word    = bus_addr[ADDR_W-1:2];
  assign wr_ok   = bus_en & bus_we & (bus_addr[1:0] == 2'b00);
  assign wr_ctrl = wr_ok & (word == W_CTRL);
  assign wr_stat = wr_ok & (word == W_STAT);
  assign wr_load = wr_ok & (word == W_LOAD);
  assign wr_cmp  = wr_ok & (word == W_CMP);
  assign wr_cnt  = wr_ok & (word == W_CNT);

  always_comb begin
    ctrl_d = ctrl_q;
    srst_d = 1'b0;
    load_d = load_q;
    cmp_d  = cmp_q;
    if (srst_q) ctrl_d = '0;
    if (wr_ctrl) begin
      if (bus_wdata[B_SRST]) begin
        ctrl_d = '0;
        srst_d = 1'b1;
      end else begin
        ctrl_d.run      = bus_wdata[B_RUN];
        ctrl_d.irq_en   = bus_wdata[B_IRQEN];
        ctrl_d.reload   = bus_wdata[B_RELOAD];
        ctrl_d.force_ld = bus_wdata[B_FORCE];
        ctrl_d.presc    = bus_wdata[B_PRE_LO +: PRE_W];
        ctrl_d.mode     = pin_mode_e'(bus_wdata[B_MODE_LO +: 2]);
      end
    end
    if (wr_load) load_d = bus_wdata[CNT_W-1:0];
    if (wr_cmp)  cmp_d  = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      srst_q <= 1'b0;
      load_q <= '0;
      cmp_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      srst_q <= srst_d;
      load_q <= load_d;
      cmp_q  <= cmp_d;
    end
  end

  cdt_prescale #(.PW(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(srst_q), .run(ctrl_q.run),
    .limit(ctrl_q.presc), .tick(tick)
  );

  assign force_wr = wr_load & ctrl_q.force_ld;

  cdt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(srst_q), .tick(tick),
    .reload(ctrl_q.reload), .load_val(load_q),
    .force_wr(force_wr), .force_val(bus_wdata[CNT_W-1:0]),
    .cnt(cnt), .step_val(step_val)
  );

  assign evt = tick & ~force_wr & (step_val == cmp_q);

  cdt_event u_evt (
    .clk(clk), .rst_n(rst_n), .clr(srst_q), .evt(evt),
    .clr_req(wr_stat & bus_wdata[0]), .mode(ctrl_q.mode),
    .flag(flag), .pin_o(pin_out)
  );

  assign irq = flag & ctrl_q.irq_en;

  always_comb begin
    bus_rdata = '0;
    case (word)
      W_CTRL: begin
        bus_rdata[B_RUN]             = ctrl_q.run;
        bus_rdata[B_IRQEN]           = ctrl_q.irq_en;
        bus_rdata[B_RELOAD]          = ctrl_q.reload;
        bus_rdata[B_PRE_LO +: PRE_W] = ctrl_q.presc;
        bus_rdata[B_SRST]            = srst_q;
        bus_rdata[B_FORCE]           = ctrl_q.force_ld;
        bus_rdata[B_MODE_LO +: 2]    = ctrl_q.mode;
      end
      W_STAT:  bus_rdata[0] = flag;
      W_LOAD:  bus_rdata = DATA_W'(load_q);
      W_CMP:   bus_rdata = DATA_W'(cmp_q);
      W_CNT:   bus_rdata = DATA_W'(cnt);
      default: bus_rdata = '0;
    endcase
  end

  p_srst_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (cnt == '0 && !flag && !srst_q));
  p_cnt_readonly_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !tick && !srst_q) |=> $stable(cnt));
endmodule

// File: tb/cmp_dn_timer_tb.sv
`timescale 1ns/1ps
module cmp_dn_timer_tb;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_LOAD = 5'h08,
                         A_CMP  = 5'h0C, A_CNT  = 5'h10;
  localparam logic [31:0] RUN = 32'h1, IRQEN = 32'h4, RLD = 32'h8,
                          SRST = 32'h1_0000, FRC = 32'h2_0000,
                          M_TOG = 32'h40_0000, M_LOW = 32'h80_0000, M_HIGH = 32'hC0_0000;

  logic clk, rst_n, bus_en, bus_we, irq, pin_out;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int n_chk, n_fail;
  bit done;

  int          kq[$];
  logic [31:0] eq[$];
  string       tq[$];

  cmp_dn_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .pin_out(pin_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    bus_addr = a;
    kq.push_back(0); eq.push_back(e); tq.push_back(t);
  endtask

  task automatic chk_irq(input logic e, input string t);
    kq.push_back(1); eq.push_back({31'b0, e}); tq.push_back(t);
  endtask

  task automatic chk_pin(input logic e, input string t);
    kq.push_back(2); eq.push_back({31'b0, e}); tq.push_back(t);
  endtask

  // monitor: compares queued expectations one time unit after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (kq.size() > 0) begin
        int k;
        logic [31:0] e, act;
        string t;
        k = kq.pop_front(); e = eq.pop_front(); t = tq.pop_front();
        act = (k == 0) ? bus_rdata : (k == 1) ? {31'b0, irq} : {31'b0, pin_out};
        n_chk++;
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", t, act, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, 0, "R1 ctrl"); step();
    rd(A_STAT, 0, "R1 stat"); step();
    rd(A_LOAD, 0, "R1 load"); step();
    rd(A_CMP, 0, "R1 cmp"); step();
    rd(A_CNT, 0, "R1 cnt"); chk_irq(0, "R1 irq"); chk_pin(0, "R1 pin"); step();

    // R5 forced load, R11 read-only counter
    wr(A_CTRL, FRC);
    wr(A_LOAD, 32'd10);
    rd(A_CNT, 32'd10, "R5 forced load"); step();
    wr(A_CNT, 32'h55);
    rd(A_CNT, 32'd10, "R11 counter write ignored"); step();
    wr(A_CTRL, 0);
    wr(A_LOAD, 32'd99);
    rd(A_CNT, 32'd10, "R5 unforced load leaves counter"); step();
    rd(A_LOAD, 32'd99, "R5 load register"); step();

    // R2 prescale 0
    wr(A_CTRL, RUN);
    for (int k = 1; k <= 4; k++) begin
      rd(A_CNT, 32'd10 - 32'(k - 1), "R2 step P=0"); step();
    end
    wr(A_CTRL, 0);
    rd(A_CNT, 32'd5, "R2 stop"); step();
    rd(A_CNT, 32'd5, "R2 hold"); step();

    // R2 prescale 2
    wr(A_CTRL, FRC);
    wr(A_LOAD, 32'd20);
    wr(A_CTRL, RUN | (32'd2 << 4));
    for (int k = 1; k <= 7; k++) begin
      rd(A_CNT, 32'd20 - 32'((k - 1) / 3), "R2 step P=2"); step();
    end
    wr(A_CTRL, 0);

    // R3 free-running wrap
    wr(A_CTRL, FRC);
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, RUN);
    rd(A_CNT, 32'd2, "R3 pre"); step();
    rd(A_CNT, 32'd1, "R3 pre"); step();
    rd(A_CNT, 32'd0, "R3 zero"); step();
    rd(A_CNT, 32'hFFFF_FFFF, "R3 wrap"); step();
    rd(A_CNT, 32'hFFFF_FFFE, "R3 after wrap"); step();
    wr(A_CTRL, 0);

    // R4 reload
    wr(A_CTRL, FRC);
    wr(A_LOAD, 32'd1);
    wr(A_CTRL, 0);
    wr(A_LOAD, 32'd7);
    rd(A_CNT, 32'd1, "R5 unforced load"); step();
    wr(A_CTRL, RUN | RLD);
    rd(A_CNT, 32'd1, "R4 pre"); step();
    rd(A_CNT, 32'd0, "R4 zero"); step();
    rd(A_CNT, 32'd7, "R4 reload"); step();
    rd(A_CNT, 32'd6, "R4 after reload"); step();
    wr(A_CTRL, 0);

    // R6 compare, R8 irq, R9 toggle
    wr(A_CMP, 32'd3);
    wr(A_STAT, 32'd1);
    wr(A_CTRL, FRC);
    wr(A_LOAD, 32'd5);
    wr(A_CTRL, RUN | IRQEN | M_TOG);
    rd(A_CNT, 32'd5, "R6 start"); chk_pin(0, "R9 pin before"); chk_irq(0, "R8 idle"); step();
    rd(A_STAT, 0, "R6 no early flag"); step();
    rd(A_STAT, 1, "R6 flag on match"); chk_irq(1, "R8 irq"); chk_pin(1, "R9 toggle"); step();
    wr(A_CTRL, IRQEN | M_TOG);
    rd(A_STAT, 1, "R6 flag sticky"); chk_irq(1, "R8 irq held"); step();
    wr(A_CTRL, M_TOG);
    rd(A_STAT, 1, "R8 flag kept"); chk_irq(0, "R8 masked"); chk_pin(1, "R9 pin held"); step();
    wr(A_STAT, 32'd0);
    rd(A_STAT, 1, "R7 write zero"); step();
    wr(A_STAT, 32'd1);
    rd(A_STAT, 0, "R7 write one clears"); step();

    // R9 drive-low mode
    wr(A_CTRL, FRC);
    wr(A_LOAD, 32'd5);
    wr(A_CTRL, RUN | M_LOW);
    chk_pin(1, "R9 low pre"); step();
    step();
    chk_pin(0, "R9 low"); step();
    wr(A_CTRL, M_LOW);

    // R9 drive-high mode
    wr(A_STAT, 32'd1);
    wr(A_CTRL, FRC);
    wr(A_LOAD, 32'd5);
    wr(A_CTRL, RUN | M_HIGH);
    chk_pin(0, "R9 high pre"); step();
    step();
    chk_pin(1, "R9 high"); step();
    wr(A_CTRL, M_HIGH);
    wr(A_CTRL, 0);
    chk_pin(0, "R9 disconnected"); step();

    // R7 set wins over simultaneous clear
    wr(A_STAT, 32'd1);
    wr(A_CTRL, FRC);
    wr(A_LOAD, 32'd5);
    wr(A_CTRL, RUN);
    step();
    wr(A_STAT, 32'd1);
    rd(A_STAT, 1, "R7 event beats clear"); step();
    wr(A_CTRL, 0);

    // R10 soft reset
    wr(A_CTRL, RUN | IRQEN | M_HIGH | (32'd5 << 4));
    chk_irq(1, "R10 irq before"); step();
    wr(A_CTRL, SRST | RUN);
    rd(A_CTRL, SRST, "R10 reset bit visible"); step();
    rd(A_CTRL, 0, "R10 reset bit self-clears"); chk_irq(0, "R10 irq"); step();
    rd(A_CNT, 0, "R10 counter"); step();
    rd(A_STAT, 0, "R10 status"); step();
    rd(A_LOAD, 32'd5, "R10 load kept"); step();
    wr(A_CTRL, M_TOG);
    rd(A_CMP, 32'd3, "R10 compare kept"); chk_pin(0, "R10 pin state"); step();

    step();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule